// File: doc/BRIEF.md
# Processor Status Word with Maskable Interrupt Gate

This block keeps the part of a processor status word that governs maskable interrupts and register banks. It holds three fields: a global interrupt enable bit, a two-bit register bank number and a two-bit in-service priority level. The decoder drives single-cycle strobes for enable-interrupts, disable-interrupts and select-bank instructions. A restore strobe loads every field at once, which models a return from an interrupt handler.

A combinational gate looks at the pending maskable request, its mask bit and its two-bit priority. It raises `accept_o` only when the request may be taken. When the interrupt controller acknowledges an accepted request, the block clears the global enable and loads the in-service level with that request's priority in the same cycle. Priority 0 is the most urgent and 3 the least.

Top module: `status_gate`

## Requirements
- R1: After reset the enable bit is 0, the bank field is 0 and the in-service level is 3, the least urgent value.
- R2: While the enable bit is 0, `accept_o` stays 0 for every request, mask and priority.
- R3: A request whose mask bit is 1 never raises `accept_o`.
- R4: `accept_o` is 1 exactly when the enable bit is 1, a request is pending, its mask bit is 0 and its priority value is numerically less than or equal to the in-service level (0 most urgent, 3 least).
- R5: An enable strobe sets the enable bit on the next clock and a disable strobe clears it. When both strobes arrive in the same cycle, disable wins.
- R6: An acknowledge in a cycle where `accept_o` is 1 clears the enable bit and loads the in-service level with the request priority, both on the next clock. This takes precedence over enable and disable strobes.
- R7: An acknowledge in a cycle where `accept_o` is 0 changes neither the enable bit nor the in-service level.
- R8: A bank-select strobe loads the two-bit bank number on the next clock. The bank field otherwise holds its value.
- R9: A restore strobe loads the enable bit, bank and level from the restore inputs on the next clock, overriding every other strobe in that cycle.
- R10: With no request pending, `accept_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ei_i | input | 1 | Enable-interrupts instruction strobe |
| di_i | input | 1 | Disable-interrupts instruction strobe |
| bank_we_i | input | 1 | Select-bank instruction strobe |
| bank_num_i | input | 2 | Bank number for select-bank |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| irq_pend_i | input | 1 | Maskable request pending |
| irq_mask_i | input | 1 | Mask bit of the pending source, 1 blocks it |
| irq_prio_i | input | 2 | Priority of the pending source |
| restore_i | input | 1 | Parallel load of all status fields |
| restore_ie_i | input | 1 | Enable bit to restore |
| restore_bank_i | input | 2 | Bank number to restore |
| restore_lvl_i | input | 2 | In-service level to restore |
| accept_o | output | 1 | Pending request may be taken |
| ie_o | output | 1 | Global interrupt enable bit |
| bank_o | output | 2 | Current register bank |
| lvl_o | output | 2 | Current in-service priority level |

## Verification
The bench sweeps every combination of enable bit, in-service level, mask, pending and priority. Each combination is tried both with and without an acknowledge. This catches a comparison that is inverted, strict or off by one; such a design would reject a request at the same level or take a less urgent one. A design that acknowledged without accepting would show a changed level or a cleared enable after an ignored acknowledge. The bench also drives colliding strobes: enable with disable, acknowledge with enable, and restore with acknowledge and select-bank. A design with the wrong precedence would leave the enable bit or bank field at the losing value.

// File: rtl/status_gate_pkg.sv
package status_gate_pkg;
  parameter int unsigned LVL_W  = 2;
  parameter int unsigned BANK_W = 2;

  localparam logic [LVL_W-1:0] LVL_LOWEST = {LVL_W{1'b1}};

  typedef struct packed {
    logic              ie;
    logic [BANK_W-1:0] bank;
    logic [LVL_W-1:0]  lvl;
  } stat_t;
endpackage

// File: rtl/status_gate_cmp.sv
module status_gate_cmp
  import status_gate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ie_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic             pend_i,
  input  logic             mask_i,
  input  logic [LVL_W-1:0] prio_i,
  output logic             accept_o
);
  // 0 is most urgent: equal-or-more-urgent requests pass
  logic prio_ok;
  assign prio_ok  = (prio_i <= lvl_i);
  assign accept_o = ie_i & pend_i & ~mask_i & prio_ok;

  p_disabled_blocks_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !accept_o);
  p_masked_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !accept_o);
  p_no_less_urgent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (prio_i <= lvl_i));
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pend_i |-> !accept_o);
endmodule

// File: rtl/status_gate_reg.sv
module status_gate_reg
  import status_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_num_i,
  input  logic              take_i,
  input  logic [LVL_W-1:0]  take_lvl_i,
  input  logic              restore_i,
  input  stat_t             restore_val_i,
  output stat_t             stat_o
);
  stat_t q, d;

  always_comb begin
    d = q;
    if (restore_i) begin
      d = restore_val_i;
    end else begin
      if (take_i) begin
        d.ie  = 1'b0;
        d.lvl = take_lvl_i;
      end else if (di_i) begin
        d.ie = 1'b0;
      end else if (ei_i) begin
        d.ie = 1'b1;
      end
      if (bank_we_i) d.bank = bank_num_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.ie   <= 1'b0;
      q.bank <= '0;
      q.lvl  <= LVL_LOWEST;
    end else begin
      q <= d;
    end
  end

  assign stat_o = q;

  p_restore_loads_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (q == $past(restore_val_i)));
  p_take_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !restore_i) |=> (!q.ie && q.lvl == $past(take_lvl_i)));
  p_ei_sets_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ei_i && !di_i && !take_i && !restore_i) |=> q.ie);
  p_di_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (di_i && !restore_i) |=> !q.ie);
  p_lvl_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_i && !restore_i) |=> $stable(q.lvl));
  p_bank_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_i && !restore_i) |=> (q.bank == $past(bank_num_i)));
  p_bank_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bank_we_i && !restore_i) |=> $stable(q.bank));
endmodule

// File: rtl/status_gate.sv
module status_gate
  import status_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ei_i,
  input  logic              di_i,
  input  logic              bank_we_i,
  input  logic [BANK_W-1:0] bank_num_i,
  input  logic              ack_i,
  input  logic              irq_pend_i,
  input  logic              irq_mask_i,
  input  logic [LVL_W-1:0]  irq_prio_i,
  input  logic              restore_i,
  input  logic              restore_ie_i,
  input  logic [BANK_W-1:0] restore_bank_i,
  input  logic [LVL_W-1:0]  restore_lvl_i,
  output logic              accept_o,
  output logic              ie_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [LVL_W-1:0]  lvl_o
);
  stat_t stat, rval;
  logic  accept;

  assign rval.ie   = restore_ie_i;
  assign rval.bank = restore_bank_i;
  assign rval.lvl  = restore_lvl_i;

  status_gate_cmp u_cmp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ie_i     (stat.ie),
    .lvl_i    (stat.lvl),
    .pend_i   (irq_pend_i),
    .mask_i   (irq_mask_i),
    .prio_i   (irq_prio_i),
    .accept_o (accept)
  );

  status_gate_reg u_reg (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ei_i          (ei_i),
    .di_i          (di_i),
    .bank_we_i     (bank_we_i),
    .bank_num_i    (bank_num_i),
    .take_i        (ack_i & accept),
    .take_lvl_i    (irq_prio_i),
    .restore_i     (restore_i),
    .restore_val_i (rval),
    .stat_o        (stat)
  );

  assign accept_o = accept;
  assign ie_o     = stat.ie;
  assign bank_o   = stat.bank;
  assign lvl_o    = stat.lvl;

  p_ack_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !accept_o && !restore_i && !di_i && !ei_i) |=> ($stable(ie_o) && $stable(lvl_o)));
endmodule

// File: tb/status_gate_bench.sv
`timescale 1ns/1ps
module status_gate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ei = 0, di = 0, bwe = 0, ack = 0, pend = 0, mask = 0, rst_st = 0, r_ie = 0;
  logic [1:0] bnum = 0, prio = 0, r_bank = 0, r_lvl = 0;
  logic accept, ie;
  logic [1:0] bank, lvl;

  int checks = 0;
  int fails  = 0;
  logic       m_ie;
  logic [1:0] m_bank, m_lvl;

  always #2.5 clk = ~clk;

  status_gate u_status_gate (
    .clk_i(clk), .rst_ni(rst_n), .ei_i(ei), .di_i(di), .bank_we_i(bwe),
    .bank_num_i(bnum), .ack_i(ack), .irq_pend_i(pend), .irq_mask_i(mask),
    .irq_prio_i(prio), .restore_i(rst_st), .restore_ie_i(r_ie),
    .restore_bank_i(r_bank), .restore_lvl_i(r_lvl), .accept_o(accept),
    .ie_o(ie), .bank_o(bank), .lvl_o(lvl)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ei = 0; di = 0; bwe = 0; ack = 0; pend = 0; mask = 0; rst_st = 0;
  endtask

  // inputs already driven after a negedge; check accept, clock, check state
  task automatic step(input string req);
    logic exp_acc;
    #1;
    exp_acc = m_ie && pend && !mask && (prio <= m_lvl);
    chk({req, " accept"}, int'(accept), int'(exp_acc));
    if (rst_st) begin
      m_ie = r_ie; m_bank = r_bank; m_lvl = r_lvl;
    end else begin
      if (ack && exp_acc) begin m_ie = 0; m_lvl = prio; end
      else if (di) m_ie = 0;
      else if (ei) m_ie = 1;
      if (bwe) m_bank = bnum;
    end
    @(posedge clk); #1;
    chk({req, " ie"},   int'(ie),   int'(m_ie));
    chk({req, " bank"}, int'(bank), int'(m_bank));
    chk({req, " lvl"},  int'(lvl),  int'(m_lvl));
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_ie = 0; m_bank = 0; m_lvl = 3;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ie", int'(ie), 0);
    chk("R1 bank", int'(bank), 0);
    chk("R1 lvl", int'(lvl), 3);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 enable, disable, collision
    ei = 1; step("R5 ei");
    di = 1; step("R5 di");
    ei = 1; di = 1; step("R5 both");
    chk("R5 di wins", int'(ie), 0);

    // R8 every bank number
    for (int b = 0; b < 4; b++) begin
      bwe = 1; bnum = 2'(b); step("R8 select");
      bnum = 2'(3 - b); step("R8 hold");
    end

    // R6 ack beats ei; R9 restore beats ack and bank select
    ei = 1; step("R5 ei");
    pend = 1; prio = 2; ack = 1; ei = 1; step("R6 ack beats ei");
    chk("R6 lvl", int'(lvl), 2);
    r_ie = 1; r_bank = 2; r_lvl = 1; rst_st = 1; pend = 1; prio = 0; ack = 1;
    bwe = 1; bnum = 3; di = 1; step("R9 override");
    chk("R9 bank", int'(bank), 2);

    // R2 R3 R4 R6 R7 R10 sweep
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < 4; l++)
        for (int mk = 0; mk < 2; mk++)
          for (int pd = 0; pd < 2; pd++)
            for (int p = 0; p < 4; p++)
              for (int a = 0; a < 2; a++) begin
                r_ie = e[0]; r_lvl = 2'(l); r_bank = 2'(p); rst_st = 1;
                step("R9 load");
                pend = pd[0]; mask = mk[0]; prio = 2'(p); ack = a[0];
                if (!e[0]) step("R2 disabled");
                else if (mk[0]) step("R3 masked");
                else if (!pd[0]) step("R10 idle");
                else if (a[0]) step("R6 R7 ack");
                else step("R4 compare");
              end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule